// File: doc/BRIEF.md
# Twin-Bank Prefetch Controller

This block is the operand memory of one processing node. It holds two equal buffer banks, and each bank has its own transfer engine. At any moment one bank faces the processor, which reads its input words and writes its result words there. The other bank faces the shared global memory. In the background it first writes the finished results of the previous segment back to global memory, then fetches the next input segment. Because the two banks trade roles after every segment, shared-memory traffic overlaps with computation.

Work arrives as segment descriptors. Each descriptor carries two global word addresses: where the segment's input words are read from, and where its result words are written to. A segment occupies SEG_WORDS local words. The lower half holds input and the upper half holds results. The processor announces the end of a segment with a one-cycle done strobe and then waits. The banks swap as soon as both the processor and the background engine have finished their current work. When no descriptor is left to fetch, the last swap only writes back results, and the block then raises an idle/done flag.

Top module: `pingpong_prefetch`

## Requirements
- R1: After reset, cpu_stall=1, done=0, mem_req=0 and desc_ready=1.
- R2: A descriptor is accepted in a cycle where desc_valid and desc_ready are both 1. In the next cycle the block requests the first read (mem_req=1, mem_we=0) at the descriptor's input base.
- R3: A load issues exactly SEG_WORDS/2 reads, at input base +0, +1, ... in order. Returned words are stored in local offsets 0 upward, in the order they return.
- R4: While cpu_stall=0, a processor write with cpu_en=1 and cpu_we=1 stores cpu_wdata at local offset cpu_addr of the processor-facing bank. A read with cpu_en=1 and cpu_we=0 presents that word on cpu_rdata in the following cycle.
- R5: A cpu_seg_done strobe while cpu_stall=0 raises cpu_stall in the next cycle. While cpu_stall=1, processor writes and cpu_seg_done have no effect.
- R6: cpu_stall falls only through a swap, and only when the background bank has completed its load. After the swap, offsets 0..SEG_WORDS/2-1 hold the next segment's input.
- R7: When a finished bank moves to the background, it first writes local offsets SEG_WORDS/2 upward to result base +0, +1, ... in order. Only after the last of these writes does it load the next descriptor.
- R8: If no descriptor is waiting when the processor finishes, the swap only writes back the results, and done=1 follows. done=1 never coincides with mem_req=1.
- R9: A pending request (mem_req=1, mem_gnt=0) keeps mem_req, mem_we and mem_addr unchanged until it is granted. Read data is taken in order on mem_rvalid, with any latency.
- R10: While the processor works on a segment, desc_ready stays high whenever the background bank is empty. The next segment is then fetched during the computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be accepted |
| desc_in_base | input | GAW | Global word address of segment input |
| desc_res_base | input | GAW | Global word address for segment results |
| cpu_en | input | 1 | Processor access strobe |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | LA | Local word offset |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data, one cycle after request |
| cpu_seg_done | input | 1 | Processor finished its segment |
| cpu_stall | output | 1 | Processor must wait |
| mem_req | output | 1 | Global memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | GAW | Global word address |
| mem_wdata | output | DW | Global write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| done | output | 1 | All accepted segments processed and written back |

## Verification
The hardest condition to reach is the final writeback-only swap in the middle of a run. The background bank must be empty exactly when the processor finishes, and a new descriptor must arrive only afterwards. The stimulus therefore holds back one descriptor until done rises, which forces a swap with nothing to load. It then resumes feeding, so the block must leave the done state cleanly. Random grant gaps and random read-return delays stretch the loads and writebacks. As a result, the processor sometimes waits on the background bank and the background bank sometimes waits on the processor.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [2:0] {
    XS_IDLE   = 3'd0,
    XS_UNLOAD = 3'd1,
    XS_PICK   = 3'd2,
    XS_LOAD   = 3'd3,
    XS_READY  = 3'd4
  } xfer_st_t;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int LA   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [LA-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [LA-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [LA-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign ra_data = store[ra_addr];
  assign rb_data = store[rb_addr];
endmodule

// File: rtl/pp_xfer.sv
module pp_xfer
  import pp_pkg::*;
#(
  parameter int DW        = 32,
  parameter int GAW       = 10,
  parameter int SEG_WORDS = 64,
  localparam int LA       = $clog2(SEG_WORDS),
  localparam int HALF     = SEG_WORDS / 2,
  localparam int CW       = $clog2(HALF) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           is_bg,
  input  logic           swap,
  input  logic           start_unload,
  input  logic           desc_valid,
  input  logic [GAW-1:0] desc_in_base,
  input  logic [GAW-1:0] desc_res_base,
  output logic           can_take,
  output logic           took,
  output logic           st_idle,
  output logic           st_ready,
  output logic           mem_req,
  output logic           mem_we,
  output logic [GAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_gnt,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic [LA-1:0]  bank_raddr,
  input  logic [DW-1:0]  bank_rdata,
  output logic           bank_we,
  output logic [LA-1:0]  bank_waddr,
  output logic [DW-1:0]  bank_wdata
);
  xfer_st_t       st_q, st_d;
  logic [CW-1:0]  icnt_q, icnt_d;
  logic [CW-1:0]  rcnt_q, rcnt_d;
  logic [GAW-1:0] in_base_q, res_base_q;
  logic           issue_ok;
  logic           last_issue, last_return;

  assign can_take    = is_bg && !swap && (st_q == XS_IDLE || st_q == XS_PICK);
  assign took        = can_take && desc_valid;
  assign st_idle     = (st_q == XS_IDLE);
  assign st_ready    = (st_q == XS_READY);
  assign issue_ok    = (icnt_q < CW'(HALF));
  assign last_issue  = (icnt_q == CW'(HALF - 1));
  assign last_return = (rcnt_q == CW'(HALF - 1));

  assign mem_req    = (st_q == XS_UNLOAD) || (st_q == XS_LOAD && issue_ok);
  assign mem_we     = (st_q == XS_UNLOAD);
  assign mem_addr   = (st_q == XS_UNLOAD ? res_base_q : in_base_q) + GAW'(icnt_q);
  assign mem_wdata  = bank_rdata;
  assign bank_raddr = LA'(HALF) + LA'(icnt_q);
  assign bank_we    = (st_q == XS_LOAD) && mem_rvalid;
  assign bank_waddr = LA'(rcnt_q);
  assign bank_wdata = mem_rdata;

  always_comb begin
    st_d   = st_q;
    icnt_d = icnt_q;
    rcnt_d = rcnt_q;
    unique case (st_q)
      XS_IDLE: begin
        if (start_unload) begin
          st_d   = XS_UNLOAD;
          icnt_d = '0;
        end else if (took) begin
          st_d   = XS_LOAD;
          icnt_d = '0;
          rcnt_d = '0;
        end
      end
      XS_UNLOAD: begin
        if (mem_gnt) begin
          icnt_d = icnt_q + 1'b1;
          if (last_issue) st_d = XS_PICK;
        end
      end
      XS_PICK: begin
        icnt_d = '0;
        rcnt_d = '0;
        st_d   = took ? XS_LOAD : XS_IDLE;
      end
      XS_LOAD: begin
        if (mem_req && mem_gnt) icnt_d = icnt_q + 1'b1;
        if (mem_rvalid) begin
          rcnt_d = rcnt_q + 1'b1;
          if (last_return) st_d = XS_READY;
        end
      end
      XS_READY: begin
        if (swap && is_bg) st_d = XS_IDLE;
      end
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= XS_IDLE;
      icnt_q     <= '0;
      rcnt_q     <= '0;
      in_base_q  <= '0;
      res_base_q <= '0;
    end else begin
      st_q   <= st_d;
      icnt_q <= icnt_d;
      rcnt_q <= rcnt_d;
      if (took) begin
        in_base_q  <= desc_in_base;
        res_base_q <= desc_res_base;
      end
    end
  end
endmodule

// File: rtl/pingpong_prefetch.sv
module pingpong_prefetch #(
  parameter int DW        = 32,
  parameter int GAW       = 10,
  parameter int SEG_WORDS = 64,
  localparam int LA       = $clog2(SEG_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           desc_valid,
  output logic           desc_ready,
  input  logic [GAW-1:0] desc_in_base,
  input  logic [GAW-1:0] desc_res_base,
  input  logic           cpu_en,
  input  logic           cpu_we,
  input  logic [LA-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  input  logic           cpu_seg_done,
  output logic           cpu_stall,
  output logic           mem_req,
  output logic           mem_we,
  output logic [GAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_gnt,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic           done
);
  localparam int NB = 2;

  logic fg_q, fg_d;
  logic fg_has_q, fg_has_d;
  logic fg_fin_q, fg_fin_d;
  logic seen_q, seen_d;
  logic bg;
  logic swap, bg_idle, bg_ready, cpu_go, any_took;
  logic [DW-1:0] rdata_q;

  logic [NB-1:0]          x_can_take, x_took, x_idle, x_ready;
  logic [NB-1:0]          x_req, x_we, x_bank_we, x_is_bg, x_start;
  logic [GAW-1:0]         x_addr   [NB];
  logic [DW-1:0]          x_wdata  [NB];
  logic [LA-1:0]          x_braddr [NB];
  logic [LA-1:0]          x_bwaddr [NB];
  logic [DW-1:0]          x_bwdata [NB];
  logic [DW-1:0]          b_ra     [NB];
  logic [DW-1:0]          b_rb     [NB];
  logic [NB-1:0]          b_we;
  logic [LA-1:0]          b_waddr  [NB];
  logic [DW-1:0]          b_wdata  [NB];

  assign bg        = ~fg_q;
  assign bg_idle   = x_idle[bg];
  assign bg_ready  = x_ready[bg];
  assign swap      = (bg_idle || bg_ready) && (fg_fin_q || !fg_has_q) &&
                     (bg_ready || fg_fin_q);
  assign cpu_stall = !(fg_has_q && !fg_fin_q);
  assign cpu_go    = cpu_en && !cpu_stall;
  assign any_took  = |x_took;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_side
      assign x_is_bg[g] = (g != int'(fg_q));
      assign x_start[g] = swap && (g == int'(fg_q)) && fg_has_q;

      pp_xfer #(.DW(DW), .GAW(GAW), .SEG_WORDS(SEG_WORDS)) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .is_bg        (x_is_bg[g]),
        .swap         (swap),
        .start_unload (x_start[g]),
        .desc_valid   (desc_valid),
        .desc_in_base (desc_in_base),
        .desc_res_base(desc_res_base),
        .can_take     (x_can_take[g]),
        .took         (x_took[g]),
        .st_idle      (x_idle[g]),
        .st_ready     (x_ready[g]),
        .mem_req      (x_req[g]),
        .mem_we       (x_we[g]),
        .mem_addr     (x_addr[g]),
        .mem_wdata    (x_wdata[g]),
        .mem_gnt      (mem_gnt && x_is_bg[g]),
        .mem_rvalid   (mem_rvalid && x_is_bg[g]),
        .mem_rdata    (mem_rdata),
        .bank_raddr   (x_braddr[g]),
        .bank_rdata   (b_rb[g]),
        .bank_we      (x_bank_we[g]),
        .bank_waddr   (x_bwaddr[g]),
        .bank_wdata   (x_bwdata[g])
      );

      always_comb begin
        if (g == int'(fg_q)) begin
          b_we[g]    = cpu_go && cpu_we;
          b_waddr[g] = cpu_addr;
          b_wdata[g] = cpu_wdata;
        end else begin
          b_we[g]    = x_bank_we[g];
          b_waddr[g] = x_bwaddr[g];
          b_wdata[g] = x_bwdata[g];
        end
      end

      pp_bank #(.DW(DW), .DEPTH(SEG_WORDS)) u_bank (
        .clk    (clk),
        .wr_en  (b_we[g]),
        .wr_addr(b_waddr[g]),
        .wr_data(b_wdata[g]),
        .ra_addr(cpu_addr),
        .ra_data(b_ra[g]),
        .rb_addr(x_braddr[g]),
        .rb_data(b_rb[g])
      );
    end
  endgenerate

  assign desc_ready = x_can_take[bg];
  assign mem_req    = x_req[bg];
  assign mem_we     = x_we[bg];
  assign mem_addr   = x_addr[bg];
  assign mem_wdata  = x_wdata[bg];
  assign cpu_rdata  = rdata_q;
  assign done       = seen_q && !fg_has_q && bg_idle;

  always_comb begin
    fg_d     = fg_q;
    fg_has_d = fg_has_q;
    fg_fin_d = fg_fin_q;
    seen_d   = seen_q || any_took;
    if (swap) begin
      fg_d     = bg;
      fg_has_d = bg_ready;
      fg_fin_d = 1'b0;
    end else if (cpu_seg_done && !cpu_stall) begin
      fg_fin_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fg_q     <= 1'b0;
      fg_has_q <= 1'b0;
      fg_fin_q <= 1'b0;
      seen_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      fg_q     <= fg_d;
      fg_has_q <= fg_has_d;
      fg_fin_q <= fg_fin_d;
      seen_q   <= seen_d;
      if (cpu_go && !cpu_we) rdata_q <= b_ra[fg_q];
    end
  end
endmodule

// File: rtl/pingpong_prefetch_chk.sv
module pingpong_prefetch_chk #(
  parameter int GAW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cpu_seg_done,
  input logic           cpu_stall,
  input logic           desc_valid,
  input logic           desc_ready,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_gnt,
  input logic [GAW-1:0] mem_addr,
  input logic           done,
  input logic           bg_ready
);
  p_stall_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_seg_done && !cpu_stall) |=> cpu_stall);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_take_starts_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |=> (mem_req && !mem_we));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  p_swap_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> $past(bg_ready));
endmodule

bind pingpong_prefetch pingpong_prefetch_chk #(.GAW(GAW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_seg_done(cpu_seg_done),
  .cpu_stall   (cpu_stall),
  .desc_valid  (desc_valid),
  .desc_ready  (desc_ready),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_gnt     (mem_gnt),
  .mem_addr    (mem_addr),
  .done        (done),
  .bg_ready    (bg_ready)
);

// File: tb/pingpong_prefetch_test.sv
module pingpong_prefetch_test;
  localparam int DW = 32, GAW = 10, SEG = 64, LA = 6, HALF = 32, NSEG = 8;
  localparam int GMEM = 1 << GAW;

  logic clk, rst_n;
  logic desc_valid, desc_ready;
  logic [GAW-1:0] desc_in_base, desc_res_base;
  logic cpu_en, cpu_we, cpu_seg_done, cpu_stall;
  logic [LA-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic mem_req, mem_we, mem_gnt, mem_rvalid, done;
  logic [GAW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  pingpong_prefetch #(.DW(DW), .GAW(GAW), .SEG_WORDS(SEG)) uut (.*);

  int checks = 0, errors = 0, cycles = 0;
  logic [DW-1:0] gmem [GMEM];
  int in_b [NSEG];
  int res_b [NSEG];
  int rq [64];
  int q_wr = 0, q_rd = 0, q_n = 0;
  int n_rd = 0, n_wr = 0;
  bit took_busy = 0, finished = 0;

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [DW-1:0] in_word(int a);
    return (DW'(a) * 32'h9E3779B1) ^ 32'h00005A5A;
  endfunction
  function automatic logic [DW-1:0] res_word(int k, int i);
    return in_word(in_b[k] + i) * 3 + DW'(k);
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  // global memory model: random grants, in-order delayed read returns
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0;
    end else begin
      mem_gnt = ($urandom % 4) != 0;
      if (q_n > 0 && ($urandom % 3) != 0) begin
        mem_rvalid = 1;
        mem_rdata  = gmem[rq[q_rd]];
        q_rd = (q_rd + 1) % 64; q_n--;
      end else begin
        mem_rvalid = 0;
      end
      #1;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          // R7: results leave in order to result base + index
          check(int'(mem_addr) == res_b[n_wr / HALF] + n_wr % HALF, "R7 wr addr",
                DW'(mem_addr), DW'(res_b[n_wr / HALF] + n_wr % HALF));
          check(mem_wdata == res_word(n_wr / HALF, n_wr % HALF), "R7 wr data",
                mem_wdata, res_word(n_wr / HALF, n_wr % HALF));
          gmem[mem_addr] = mem_wdata;
          n_wr++;
        end else begin
          // R3: reads at input base + index, in order
          check(int'(mem_addr) == in_b[n_rd / HALF] + n_rd % HALF, "R3 rd addr",
                DW'(mem_addr), DW'(in_b[n_rd / HALF] + n_rd % HALF));
          rq[q_wr] = int'(mem_addr);
          q_wr = (q_wr + 1) % 64; q_n++;
          n_rd++;
        end
      end
    end
  end

  task automatic send_desc(int k);
    bit t;
    @(negedge clk);
    desc_valid = 1; desc_in_base = GAW'(in_b[k]); desc_res_base = GAW'(res_b[k]);
    do begin
      #2;
      t = desc_ready;
      if (t && !cpu_stall) took_busy = 1;
      @(negedge clk);
    end while (!t);
    desc_valid = 0;
    #2;
    // R2: first read of the new load, at the input base
    check(mem_req && !mem_we && int'(mem_addr) == in_b[k], "R2 first read",
          DW'(mem_addr), DW'(in_b[k]));
  endtask

  task automatic cpu_read(int a, output logic [DW-1:0] d);
    @(negedge clk);
    cpu_en = 1; cpu_we = 0; cpu_addr = LA'(a);
    @(negedge clk);
    cpu_en = 0;
    d = cpu_rdata;
  endtask

  task automatic cpu_write(int a, logic [DW-1:0] d);
    @(negedge clk);
    cpu_en = 1; cpu_we = 1; cpu_addr = LA'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_en = 0; cpu_we = 0;
  endtask

  // descriptor feeder
  initial begin : feeder
    desc_valid = 0; desc_in_base = '0; desc_res_base = '0;
    wait (rst_n === 1'b1);
    for (int k = 0; k < NSEG; k++) begin
      if (k == 4) begin
        while (done !== 1'b1) @(negedge clk);
        #2;
        // R8: a writeback-only swap left the block done with the bus quiet
        check(done && !mem_req, "R8 done after final writeback", DW'(done), 1);
        for (int j = 0; j < HALF; j++)
          check(gmem[res_b[3] + j] == res_word(3, j), "R8 results flushed",
                gmem[res_b[3] + j], res_word(3, j));
      end
      repeat ($urandom % 20) @(negedge clk);
      send_desc(k);
      if (k == 4) begin
        #1;
        check(!done, "R8 done clears on new work", DW'(done), 0);
      end
    end
  end

  // processor model
  initial begin : main
    logic [DW-1:0] d;
    void'($urandom(32'd20240611));
    cpu_en = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0; cpu_seg_done = 0;
    for (int a = 0; a < GMEM; a++) gmem[a] = in_word(a);
    for (int k = 0; k < NSEG; k++) begin
      in_b[k]  = k * 40 + int'($urandom % 8);
      res_b[k] = 600 + k * HALF;
    end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(cpu_stall && !done && !mem_req && desc_ready, "R1 reset state",
          {28'd0, cpu_stall, done, mem_req, desc_ready}, 32'h9);

    for (int k = 0; k < NSEG; k++) begin
      do begin @(negedge clk); #2; end while (cpu_stall);
      for (int i = 0; i < HALF; i++) begin
        cpu_read(i, d);
        // R4/R6: the new foreground bank holds this segment's input
        check(d == in_word(in_b[k] + i), "R4 R6 input word", d, in_word(in_b[k] + i));
      end
      for (int i = 0; i < HALF; i++) cpu_write(HALF + i, res_word(k, i));
      cpu_read(HALF + 5, d);
      check(d == res_word(k, 5), "R4 readback", d, res_word(k, 5));
      @(negedge clk); cpu_seg_done = 1;
      @(negedge clk); cpu_seg_done = 0;
      #1;
      check(cpu_stall, "R5 stall after seg done", DW'(cpu_stall), 1);
      // R5: a write while stalled is ignored (result check on the bus covers it)
      cpu_en = 1; cpu_we = 1; cpu_addr = LA'(HALF); cpu_wdata = 32'hDEADBEEF;
      @(negedge clk); cpu_en = 0; cpu_we = 0;
    end

    while (done !== 1'b1) @(negedge clk);
    #2;
    check(done && !mem_req, "R8 final done", DW'(done), 1);
    check(n_wr == NSEG * HALF, "R7 write count", DW'(n_wr), DW'(NSEG * HALF));
    check(n_rd == NSEG * HALF, "R3 read count", DW'(n_rd), DW'(NSEG * HALF));
    check(q_n == 0, "R9 all reads returned", DW'(q_n), 0);
    check(took_busy, "R10 prefetch during compute", DW'(took_busy), 1);
    for (int k = 0; k < NSEG; k++)
      for (int i = 0; i < HALF; i++)
        check(gmem[res_b[k] + i] == res_word(k, i), "R7 stored result",
              gmem[res_b[k] + i], res_word(k, i));
    finished = 1;
    finish_run();
  end
endmodule